// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Threshold Qualification

This block is the digital sequencer of an 8-bit successive-approximation converter. It routes one of eight analog inputs to the converter and drives a trial code to an external resistor-string DAC. It then reads a single comparator bit back, one decision per clock, until all eight bits are known. The finished code goes into a result register that software reads over a small 8-bit register bus. Each completed conversion can raise a one-cycle interrupt pulse.

Once started, the controller converts the selected input over and over until software stops it. The interrupt can be left unqualified, so that it fires on every finished code. It can also be gated by a threshold test, so that it fires only when the code is at or above a programmed limit, or only when the code is below it. This lets the converter act as a supply monitor without software reading every sample. Writing either the control register or the channel register throws away the conversion in progress. Software must therefore collect the result before touching either register.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the result register, every control register, `dac_code` and `adc_irq` are all zero.
- R2: Bits are decided from bit 7 down to bit 0. During the trial for bit k, `dac_code` holds the bits already decided above k, bit k set to 1, and zeros below k. Bit k is kept as 1 when `cmp_hi` is high, meaning the input is at or above the DAC level, and is cleared otherwise.
- R3: Setting bit 0 of the control register (address 1) starts conversions one cycle later. Each conversion takes 8 trial cycles followed by one load cycle. While that bit stays 1, conversions run back to back with a period of 9 cycles.
- R4: The result register is read at address 0. It is written only at the edge that ends a load cycle, and at that edge it takes the final code. Bus writes to address 0 are ignored.
- R5: Bits [2:0] of the channel register (address 2) select the input, and the selected input appears on `chan_sel`.
- R6: A write to address 1 or address 2 aborts any conversion in progress. In the next cycle the block is idle with `dac_code` at 0. The aborted conversion loads nothing and raises no interrupt. If the run bit is 1, a new conversion starts one cycle after that.
- R7: With bit 0 of the compare register (address 3) clear, `adc_irq` is a one-cycle pulse that is high in the cycle after every load cycle.
- R8: With compare register bit 0 set and bit 1 clear, the pulse is raised only when the new result is greater than or equal to the limit register (address 4).
- R9: With compare register bits 0 and 1 both set, the pulse is raised only when the new result is strictly less than the limit register.
- R10: Writes to addresses 3 and 4 take effect without disturbing a conversion in progress.
- R11: Reading addresses 1 to 4 returns the stored register values, with unused bits read as 0. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_hi | input | 1 | Comparator result: the input is at or above the DAC level |
| chan_sel | output | 3 | Analog input mux select |
| dac_code | output | 8 | Trial code to the resistor-string DAC |
| adc_irq | output | 1 | Conversion-complete pulse, optionally qualified by the threshold test |

## Verification
If the trial register picks up a wrong bit, the fault shows on `dac_code` in the very next trial cycle. It then reaches the result register and `adc_irq` at the end of that same conversion, at most nine cycles later. If the sequencer drifts in its bit index or state, the 9-cycle interrupt spacing breaks, or `dac_code` fails to return to zero in the cycle after an abort. A wrong comparator setup or limit shows up as an interrupt that fires or stays low, within the same conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_RESULT = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CHAN   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMPCFG = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_LIMIT  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_LOAD  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic below;   // 1: fire when result < limit, 0: fire when result >= limit
        logic en;      // threshold qualification enabled
    } cmp_cfg_t;

    function automatic logic aborts_conversion(input logic wr, input logic [ADDR_W-1:0] addr);
        return wr && (addr == ADDR_CTRL || addr == ADDR_CHAN);
    endfunction

endpackage

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int DW  = 8,
    parameter int CHW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     result,
    output logic [DW-1:0]     bus_rdata,
    output logic              run,
    output logic [CHW-1:0]    chan,
    output cmp_cfg_t          cfg,
    output logic [DW-1:0]     limit,
    output logic              restart
);

    assign restart = aborts_conversion(bus_wr, bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            chan  <= '0;
            cfg   <= '0;
            limit <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL:   run   <= bus_wdata[0];
                ADDR_CHAN:   chan  <= bus_wdata[CHW-1:0];
                ADDR_CMPCFG: cfg   <= '{below: bus_wdata[1], en: bus_wdata[0]};
                ADDR_LIMIT:  limit <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_RESULT: bus_rdata = result;
            ADDR_CTRL:   bus_rdata[0] = run;
            ADDR_CHAN:   bus_rdata[CHW-1:0] = chan;
            ADDR_CMPCFG: bus_rdata[1:0] = {cfg.below, cfg.en};
            ADDR_LIMIT:  bus_rdata = limit;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           restart,
    input  logic           cmp_hi,
    output logic [DW-1:0]  trial_code,
    output seq_state_t     st,
    output logic [$clog2(DW)-1:0] bit_idx,
    output logic           load_stb
);

    localparam int IW = $clog2(DW);
    localparam logic [IW-1:0] TOP_IDX  = IW'(DW - 1);
    localparam logic [DW-1:0] MSB_CODE = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] next_code;

    // Per-bit update for one trial step: upper bits keep, current bit takes
    // the comparator decision, the next lower bit becomes the new trial bit.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_comb begin
            if (i > int'(bit_idx))
                next_code[i] = trial_code[i];
            else if (i == int'(bit_idx))
                next_code[i] = cmp_hi;
            else if (i + 1 == int'(bit_idx))
                next_code[i] = 1'b1;
            else
                next_code[i] = 1'b0;
        end
    end

    assign load_stb = (st == ST_LOAD) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st         <= ST_IDLE;
            trial_code <= '0;
            bit_idx    <= TOP_IDX;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (run) begin
                        st         <= ST_TRIAL;
                        trial_code <= MSB_CODE;
                        bit_idx    <= TOP_IDX;
                    end
                end
                ST_TRIAL: begin
                    trial_code <= next_code;
                    if (bit_idx == '0)
                        st <= ST_LOAD;
                    else
                        bit_idx <= bit_idx - 1'b1;
                end
                ST_LOAD: begin
                    bit_idx <= TOP_IDX;
                    if (run) begin
                        st         <= ST_TRIAL;
                        trial_code <= MSB_CODE;
                    end else begin
                        st         <= ST_IDLE;
                        trial_code <= '0;
                    end
                end
                default: begin
                    st         <= ST_IDLE;
                    trial_code <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sar_result.sv
module sar_result
    import sar_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_stb,
    input  logic [DW-1:0] code,
    input  cmp_cfg_t      cfg,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] result,
    output logic          irq
);

    logic qualified;

    always_comb begin
        if (!cfg.en)
            qualified = 1'b1;
        else if (cfg.below)
            qualified = (code < limit);
        else
            qualified = (code >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= load_stb && qualified;
            if (load_stb)
                result <= code;
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic [2:0]              bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    cmp_hi,
    output logic [$clog2(NCH)-1:0]  chan_sel,
    output logic [DW-1:0]           dac_code,
    output logic                    adc_irq
);

    localparam int CHW = $clog2(NCH);
    localparam int IW  = $clog2(DW);

    logic          run_q;
    logic          restart;
    cmp_cfg_t      cfg_q;
    logic [DW-1:0] limit_q;
    logic [DW-1:0] result_q;
    seq_state_t    seq_st;
    logic [IW-1:0] seq_idx;
    logic          load_stb;

    sar_regs #(.DW(DW), .CHW(CHW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .result    (result_q),
        .bus_rdata (bus_rdata),
        .run       (run_q),
        .chan      (chan_sel),
        .cfg       (cfg_q),
        .limit     (limit_q),
        .restart   (restart)
    );

    sar_seq #(.DW(DW)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .restart    (restart),
        .cmp_hi     (cmp_hi),
        .trial_code (dac_code),
        .st         (seq_st),
        .bit_idx    (seq_idx),
        .load_stb   (load_stb)
    );

    sar_result #(.DW(DW)) res_i (
        .clk      (clk),
        .rst      (rst),
        .load_stb (load_stb),
        .code     (dac_code),
        .cfg      (cfg_q),
        .limit    (limit_q),
        .result   (result_q),
        .irq      (adc_irq)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
    import sar_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [2:0]            bus_addr,
    input  logic [DW-1:0]         dac_code,
    input  logic                  adc_irq,
    input  logic [DW-1:0]         result,
    input  seq_state_t            st,
    input  logic [$clog2(DW)-1:0] idx,
    input  cmp_cfg_t              cfg,
    input  logic [DW-1:0]         limit
);

    logic [DW-1:0] below_trial;
    logic          wr_abort;

    assign below_trial = DW'(dac_code << (DW - int'(idx)));
    assign wr_abort    = bus_wr && (bus_addr == ADDR_CTRL || bus_addr == ADDR_CHAN);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0 && !adc_irq && dac_code == '0));

    // R2
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRIAL) |-> (dac_code[idx] && below_trial == '0));

    // R3
    trial_to_load_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRIAL && idx == '0 && !wr_abort) |=> (st == ST_LOAD));

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> ($past(st) == ST_LOAD));

    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        wr_abort |=> (st == ST_IDLE && dac_code == '0 && !adc_irq));

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        adc_irq |=> !adc_irq);

    // R8
    irq_above_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_irq && cfg.en && !cfg.below && $stable(cfg) && $stable(limit)) |-> (result >= limit));

    // R9
    irq_below_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_irq && cfg.en && cfg.below && $stable(cfg) && $stable(limit)) |-> (result < limit));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .dac_code (dac_code),
    .adc_irq  (adc_irq),
    .result   (result_q),
    .st       (seq_st),
    .idx      (seq_idx),
    .cfg      (cfg_q),
    .limit    (limit_q)
);

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    wire  [7:0] bus_rdata;
    wire  [7:0] dac_code;
    wire  [2:0] chan_sel;
    wire        adc_irq;
    wire        cmp_hi;

    logic [7:0] ain [8];

    // behavioural comparator: input at or above the DAC level
    assign cmp_hi = (ain[chan_sel] >= dac_code);

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_adc_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_hi    (cmp_hi),
        .chan_sel  (chan_sel),
        .dac_code  (dac_code),
        .adc_irq   (adc_irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit chk_on = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit         m_run, m_pen, m_pmode;
    logic [2:0] m_ch;
    logic [7:0] m_lim, m_res;
    int         m_phase;   // -1 idle, 0..7 trial number, 8 load
    bit         m_irq;
    bit         r6_flag, r10_flag;
    int         cyc = 0;
    int         last_irq = -1;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_run = 0; m_ch = 0; m_pen = 0; m_pmode = 0; m_lim = 0;
            m_res = 0; m_phase = -1; m_irq = 0; last_irq = -1;
            r6_flag = 0; r10_flag = 0;
        end else begin
            m_irq = 0; r6_flag = 0; r10_flag = 0;
            if (bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2)) begin
                if (bus_addr == 3'd1) m_run = bus_wdata[0];
                else                  m_ch  = bus_wdata[2:0];
                m_phase = -1;
                last_irq = -1;
                r6_flag = 1;
            end else begin
                if (m_phase < 0) begin
                    if (m_run) m_phase = 0;
                end else if (m_phase < 8) begin
                    m_phase++;
                end else begin
                    m_res = ain[m_ch];
                    m_irq = !m_pen || (m_pmode ? (m_res < m_lim) : (m_res >= m_lim));
                    m_phase = m_run ? 0 : -1;
                end
                if (bus_wr && bus_addr == 3'd3) begin
                    m_pen = bus_wdata[0]; m_pmode = bus_wdata[1];
                    last_irq = -1;
                    if (m_phase >= 0 && m_phase < 8) r10_flag = 1;
                end
                if (bus_wr && bus_addr == 3'd4) begin
                    m_lim = bus_wdata;
                    if (m_phase >= 0 && m_phase < 8) r10_flag = 1;
                end
            end
        end
    end

    function automatic logic [7:0] exp_dac();
        logic [7:0] mask;
        int b;
        if (m_phase < 0) return 8'd0;
        if (m_phase == 8) return ain[m_ch];
        b = 7 - m_phase;
        mask = 8'hFF << (b + 1);
        return (ain[m_ch] & mask) | (8'd1 << b);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_res;
            3'd1: return {7'd0, m_run};
            3'd2: return {5'd0, m_ch};
            3'd3: return {6'd0, m_pmode, m_pen};
            3'd4: return m_lim;
            default: return 8'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk(bus_rdata == exp_rd(bus_addr), (bus_addr == 3'd0) ? "R4 result read" : "R11 register read",
                bus_rdata, exp_rd(bus_addr));
            chk(dac_code == exp_dac(), "R2 trial code", dac_code, exp_dac());
            chk(chan_sel == m_ch, "R5 channel select", chan_sel, m_ch);
            chk(adc_irq == m_irq, !m_pen ? "R7 irq every end" : (m_pmode ? "R9 irq below" : "R8 irq at or above"),
                adc_irq, m_irq);
            if (r6_flag) chk(dac_code == 8'd0, "R6 abort to idle", dac_code, 0);
            if (r10_flag) chk(dac_code == exp_dac() && dac_code != 8'd0, "R10 config write mid-run", dac_code, exp_dac());
            if (adc_irq && !m_pen) begin
                if (last_irq >= 0) chk(cyc - last_irq == 9, "R3 conversion period", cyc - last_irq, 9);
                last_irq = cyc;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'd0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk); #1;
        bus_addr = 3'd0;
    endtask

    initial begin
        ain[0] = 8'h00; ain[1] = 8'hFF; ain[2] = 8'h80; ain[3] = 8'h7F;
        ain[4] = 8'h55; ain[5] = 8'hAA; ain[6] = 8'h01; ain[7] = 8'hC3;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(bus_rdata == 8'h00, "R1 result after reset", bus_rdata, 0);
        chk(adc_irq == 1'b0, "R1 irq after reset", adc_irq, 0);
        chk(dac_code == 8'h00, "R1 dac after reset", dac_code, 0);
        chk_on = 1;
        for (int a = 1; a < 8; a++) rd(3'(a));

        // R3/R7: continuous conversions on channel 0, then 1 (abort, R6)
        wr(3'd2, 8'd0);
        wr(3'd1, 8'd1);
        wait_cyc(40);
        wr(3'd2, 8'd1);
        wait_cyc(25);
        // R4: write to result address ignored
        wr(3'd0, 8'h12);
        wait_cyc(12);
        for (int c = 2; c < 8; c++) begin
            wr(3'd2, 8'(c));
            wait_cyc(22);
        end
        // R6: abort partway through a conversion
        wr(3'd2, 8'd5);
        wait_cyc(4);
        wr(3'd2, 8'd3);
        wait_cyc(20);

        // R8: at-or-above qualification
        wr(3'd4, 8'h80);
        wr(3'd3, 8'b01);
        wr(3'd2, 8'd4);   // 0x55 < 0x80: no pulse
        wait_cyc(25);
        wr(3'd2, 8'd5);   // 0xAA >= 0x80: pulse
        wait_cyc(25);
        wr(3'd4, 8'hAA);  // equal: pulse (R10 write mid-run)
        wait_cyc(25);
        wr(3'd4, 8'hAB);  // just above: no pulse
        wait_cyc(25);
        // R9: below qualification
        wr(3'd3, 8'b11);  // 0xAA < 0xAB: pulse
        wait_cyc(25);
        wr(3'd4, 8'hAA);  // equal: no pulse
        wait_cyc(25);
        wr(3'd2, 8'd0);   // 0x00 < 0xAA: pulse
        wait_cyc(25);
        wr(3'd3, 8'b00);
        wait_cyc(3);
        wr(3'd4, 8'h33);  // R10 mid-run
        wait_cyc(20);

        // stop, change the input, restart
        wr(3'd1, 8'd0);
        wait_cyc(12);
        ain[3] = 8'h3C; ain[6] = 8'hFE;
        wr(3'd2, 8'd3);
        wr(3'd1, 8'd1);
        wait_cyc(30);
        wr(3'd2, 8'd6);
        wait_cyc(30);
        wr(3'd1, 8'd0);
        wait_cyc(5);
        for (int a = 0; a < 8; a++) rd(3'(a));
        wait_cyc(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule